// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps a horizontally microcoded datapath through a 1024-word control store. Each microinstruction holds four things: a 3-bit jump kind, a 10-bit branch target, a 2-bit dwell field that sets how many clocks it occupies, and a few control bits. The sequencer drives the control-store address `upc`, and the store returns the fields of that word combinationally. The flags of the arithmetic unit for the word now executing are also inputs. On the last clock of each word the sequencer picks the next address. The choices are: fall through, branch on carry, zero, non-negative or negative, branch always, call, or return. Calls and returns use a 16-entry circular return stack.

A host starts a run with a one-cycle `start` pulse. The run begins at address 0 and continues until a word whose carry-select and carry-value bits are both set has retired. The block then drops `busy` and raises `done` for one cycle. While a run is in progress the block adds up the dwell of every retired word into `cycle_total`. It also maintains a data-memory address latch, which is loaded either from memory read data or from the arithmetic result.

Top module: `mseq_core`

## Requirements
- R1: After reset, `busy`, `done`, `retire`, `upc`, `cycle_total` and `addr_latch` are all zero.
- R2: A `start` pulse while idle sets `busy`, clears `cycle_total` and the return-stack pointer, and makes the first retired word the one at address 0.
- R3: A `start` pulse while `busy` is high is ignored: the address trace and the cycle total of the run in progress are unchanged.
- R4: Jump kind 0 continues at `upc`+1; jump kind 5 continues at the target field.
- R5: Jump kinds 1, 2, 3 and 4 go to the target when, respectively, `alu_c` is 1, `alu_z` is 1, `alu_n` is 0, or `alu_n` is 1, and go to `upc`+1 otherwise. The flags are those present on the word's retire cycle.
- R6: Jump kind 6 pushes `upc`+1 and goes to the target. Jump kind 7 pops the most recent entry and goes there.
- R7: The return stack holds 16 entries behind a 4-bit pointer that wraps. A 17th nested push overwrites the oldest entry, and the 17th pop reads that overwritten value.
- R8: A word stays on `upc` for 2 clocks when its dwell field is 3, and for 3 plus the field value otherwise. `retire` is high on its last clock only.
- R9: When `ui_latch_en_n` is 0 on a retire cycle, `addr_latch` loads `mem_rdata` if `ui_mem_read` is 1 and `alu_y` otherwise, and the new value is visible from the next cycle. At all other times it holds.
- R10: A word retiring with `ui_cin_sel` and `ui_cin_val` both 1 ends the run. Its own jump, latch and count effects still apply, `busy` falls, `done` is high for exactly one cycle with `busy` low, and `upc` keeps the next address that word computed.
- R11: At completion `cycle_total` equals the sum of the dwell of every retired word, which is also the number of cycles `busy` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse |
| ui_jtype | input | 3 | Jump kind of the current word |
| ui_target | input | 10 | Branch or call target of the current word |
| ui_time | input | 2 | Dwell field of the current word |
| ui_cin_sel | input | 1 | Carry-select bit of the current word |
| ui_cin_val | input | 1 | Carry-value bit of the current word |
| ui_latch_en_n | input | 1 | Active-low address-latch load enable |
| ui_mem_read | input | 1 | Word reads data memory (latch source select) |
| alu_c | input | 1 | Carry flag of the current word |
| alu_z | input | 1 | Zero flag of the current word |
| alu_n | input | 1 | Sign flag of the current word |
| alu_y | input | 16 | Arithmetic result of the current word |
| mem_rdata | input | 16 | Data-memory read data for the current word |
| upc | output | 10 | Control-store address |
| retire | output | 1 | Last clock of the current word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cycle_total | output | 24 | Dwell clocks summed over the run |
| addr_latch | output | 16 | Data-memory address latch |

## Verification
`retire` is combinational and is due on the last clock of a word's dwell. The bench samples it at the falling edge, so the `upc` it compares and the clock count since the previous retire both belong to the word that is retiring. The new `upc` and the new `addr_latch` are registered at the next rising edge, so the latch is compared at the falling edge that follows a retire. `done` and the final `cycle_total` appear one edge after the last retire. The bench waits for the `done` cycle and checks the cycle total, the final address and `busy` at that point. A start accepted while idle is checked one falling edge later by `busy` being high.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   typedef enum logic [2:0] {
      JK_NEXT   = 3'd0,
      JK_CARRY  = 3'd1,
      JK_ZERO   = 3'd2,
      JK_POS    = 3'd3,
      JK_NEG    = 3'd4,
      JK_ALWAYS = 3'd5,
      JK_CALL   = 3'd6,
      JK_RET    = 3'd7
   } jump_kind_e;

   localparam int unsigned DWELL_W = 3;

   // Clocks a word occupies, from its 2-bit dwell field.
   function automatic logic [DWELL_W-1:0] dwell_of(input logic [1:0] f);
      return (f == 2'd3) ? DWELL_W'(2) : DWELL_W'(3) + DWELL_W'(f);
   endfunction

endpackage

// File: rtl/mseq_dwell.sv
module mseq_dwell
   import mseq_pkg::*;
#(
   parameter int unsigned TFW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [TFW-1:0] tfield,
   output logic           last,
   output logic [DWELL_W-1:0] dwell
);
   localparam int unsigned EW = DWELL_W;

   generate
      if (TFW != 2) begin : g_bad_tfw
         $error("mseq_dwell: dwell field must be 2 bits wide");
      end
   endgenerate

   logic [EW-1:0] elapsed;

   assign dwell = dwell_of(tfield[1:0]);
   assign last  = run && (elapsed == dwell - EW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         elapsed <= '0;
      else if (!run || last)
         elapsed <= '0;
      else
         elapsed <= elapsed + EW'(1);
   end
endmodule

// File: rtl/mseq_stack.sv
module mseq_stack #(
   parameter int unsigned AW    = 10,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_sp,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top
);
   localparam int unsigned SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("mseq_stack: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [SPW-1:0] sp;
   logic [SPW-1:0] sp_below;
   logic [AW-1:0]  slot [DEPTH];

   assign sp_below = sp - SPW'(1);
   assign top      = slot[sp_below];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp <= '0;
      else if (clear_sp)
         sp <= '0;
      else if (push)
         sp <= sp + SPW'(1);
      else if (pop)
         sp <= sp_below;
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[i] <= '0;
            else if (push && !clear_sp && sp == SPW'(i))
               slot[i] <= push_data;
         end
      end
   endgenerate
endmodule

// File: rtl/mseq_next.sv
module mseq_next
   import mseq_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic [AW-1:0] pc,
   input  logic [2:0]    jkind,
   input  logic [AW-1:0] target,
   input  logic          fc,
   input  logic          fz,
   input  logic          fn,
   input  logic [AW-1:0] stack_top,
   output logic [AW-1:0] next_pc,
   output logic [AW-1:0] link_pc,
   output logic          want_push,
   output logic          want_pop
);
   jump_kind_e kind;
   logic       taken;

   assign kind    = jump_kind_e'(jkind);
   assign link_pc = pc + AW'(1);

   always_comb begin
      taken     = 1'b0;
      want_push = 1'b0;
      want_pop  = 1'b0;
      unique case (kind)
         JK_NEXT:   taken = 1'b0;
         JK_CARRY:  taken = fc;
         JK_ZERO:   taken = fz;
         JK_POS:    taken = !fn;
         JK_NEG:    taken = fn;
         JK_ALWAYS: taken = 1'b1;
         JK_CALL: begin
            taken     = 1'b1;
            want_push = 1'b1;
         end
         JK_RET:    want_pop = 1'b1;
         default:   taken = 1'b0;
      endcase
   end

   always_comb begin
      if (want_pop)
         next_pc = stack_top;
      else if (taken)
         next_pc = target;
      else
         next_pc = link_pc;
   end
endmodule

// File: rtl/mseq_latch.sv
module mseq_latch #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          from_mem,
   input  logic [DW-1:0] mem_val,
   input  logic [DW-1:0] y_val,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= from_mem ? mem_val : y_val;
   end
endmodule

// File: rtl/mseq_core.sv
module mseq_core
   import mseq_pkg::*;
#(
   parameter int unsigned AW    = 10,
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned TFW   = 2,
   parameter int unsigned CW    = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     ui_jtype,
   input  logic [AW-1:0]  ui_target,
   input  logic [TFW-1:0] ui_time,
   input  logic           ui_cin_sel,
   input  logic           ui_cin_val,
   input  logic           ui_latch_en_n,
   input  logic           ui_mem_read,
   input  logic           alu_c,
   input  logic           alu_z,
   input  logic           alu_n,
   input  logic [DW-1:0]  alu_y,
   input  logic [DW-1:0]  mem_rdata,
   output logic [AW-1:0]  upc,
   output logic           retire,
   output logic           busy,
   output logic           done,
   output logic [CW-1:0]  cycle_total,
   output logic [DW-1:0]  addr_latch
);
   generate
      if (CW < DWELL_W) begin : g_bad_cw
         $error("mseq_core: CW too narrow for one dwell");
      end
      if (AW < 2) begin : g_bad_aw
         $error("mseq_core: AW must be at least 2");
      end
   endgenerate

   logic              accept;
   logic              finish;
   logic              last_clk;
   logic [DWELL_W-1:0] dwell;
   logic [AW-1:0]     next_pc;
   logic [AW-1:0]     link_pc;
   logic [AW-1:0]     stack_top;
   logic              want_push;
   logic              want_pop;

   assign accept = start && !busy;
   assign retire = last_clk;
   assign finish = retire && ui_cin_sel && ui_cin_val;

   mseq_dwell #(.TFW(TFW)) u_dwell (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .tfield (ui_time),
      .last   (last_clk),
      .dwell  (dwell)
   );

   mseq_next #(.AW(AW)) u_next (
      .pc        (upc),
      .jkind     (ui_jtype),
      .target    (ui_target),
      .fc        (alu_c),
      .fz        (alu_z),
      .fn        (alu_n),
      .stack_top (stack_top),
      .next_pc   (next_pc),
      .link_pc   (link_pc),
      .want_push (want_push),
      .want_pop  (want_pop)
   );

   mseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_sp  (accept),
      .push      (retire && want_push),
      .pop       (retire && want_pop),
      .push_data (link_pc),
      .top       (stack_top)
   );

   mseq_latch #(.DW(DW)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (retire && !ui_latch_en_n),
      .from_mem (ui_mem_read),
      .mem_val  (mem_rdata),
      .y_val    (alu_y),
      .q        (addr_latch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         done        <= 1'b0;
         upc         <= '0;
         cycle_total <= '0;
      end else begin
         done <= finish;
         if (accept) begin
            busy        <= 1'b1;
            upc         <= '0;
            cycle_total <= '0;
         end else if (retire) begin
            upc         <= next_pc;
            cycle_total <= cycle_total + CW'(dwell);
            if (finish)
               busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mseq_core_chk.sv
module mseq_core_chk
   import mseq_pkg::*;
#(
   parameter int unsigned AW  = 10,
   parameter int unsigned DW  = 16,
   parameter int unsigned TFW = 2,
   parameter int unsigned CW  = 24
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [2:0]     ui_jtype,
   input logic [AW-1:0]  ui_target,
   input logic [TFW-1:0] ui_time,
   input logic           ui_latch_en_n,
   input logic           ui_mem_read,
   input logic [DW-1:0]  mem_rdata,
   input logic [DW-1:0]  alu_y,
   input logic [AW-1:0]  upc,
   input logic           retire,
   input logic           busy,
   input logic           done,
   input logic [CW-1:0]  cycle_total,
   input logic [DW-1:0]  addr_latch
);
   logic [7:0]    gap;
   logic [CW-1:0] busy_clks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap       <= '0;
         busy_clks <= '0;
      end else begin
         gap <= (!busy || retire) ? 8'd0 : gap + 8'd1;
         if (start && !busy)
            busy_clks <= '0;
         else if (busy)
            busy_clks <= busy_clks + CW'(1);
      end
   end

   assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && upc == '0 && cycle_total == '0));

   assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !retire) |=> $stable(upc));

   assert_fall_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && ui_jtype == 3'd0) |=> (upc == $past(upc) + AW'(1)));

   assert_always_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && ui_jtype == 3'd5) |=> (upc == $past(ui_target)));

   assert_call_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && ui_jtype == 3'd6) |=> (upc == $past(ui_target)));

   assert_dwell_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (32'(gap) + 32'd1 == 32'(dwell_of(ui_time[1:0]))));

   assert_latch_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !ui_latch_en_n && ui_mem_read) |=> (addr_latch == $past(mem_rdata)));

   assert_latch_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !ui_latch_en_n && !ui_mem_read) |=> (addr_latch == $past(alu_y)));

   assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!retire || ui_latch_en_n) |=> $stable(addr_latch));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_total_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycle_total == busy_clks));
endmodule

bind mseq_core mseq_core_chk #(.AW(AW), .DW(DW), .TFW(TFW), .CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .ui_jtype      (ui_jtype),
   .ui_target     (ui_target),
   .ui_time       (ui_time),
   .ui_latch_en_n (ui_latch_en_n),
   .ui_mem_read   (ui_mem_read),
   .mem_rdata     (mem_rdata),
   .alu_y         (alu_y),
   .upc           (upc),
   .retire        (retire),
   .busy          (busy),
   .done          (done),
   .cycle_total   (cycle_total),
   .addr_latch    (addr_latch)
);

// File: tb/mseq_core_test.sv
`timescale 1ns/1ps
module mseq_core_test;
   localparam int AW = 10;
   localparam int DW = 16;
   localparam int CW = 24;

   typedef struct packed {
      logic [2:0]    jt;
      logic [AW-1:0] tgt;
      logic [1:0]    tm;
      logic          csel;
      logic          cval;
      logic          len_n;
      logic          rd;
      logic          c;
      logic          z;
      logic          n;
      logic [DW-1:0] y;
      logic [DW-1:0] rdata;
   } word_t;

   typedef struct {
      int          addr;
      int          dwell;
      int          latch;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   int   prog_sel = 1;
   word_t cur;

   logic [AW-1:0] upc;
   logic          retire, busy, done;
   logic [CW-1:0] cycle_total;
   logic [DW-1:0] addr_latch;

   always #2.5 clk = ~clk;

   function automatic word_t fetch(input int p, input int a);
      word_t w;
      w = '0;
      w.tm    = 2'(a);
      w.len_n = 1'b1;
      w.y     = 16'(a * 3 + 1);
      w.rdata = ~16'(a);
      if (p == 1) begin
         case (a)
            0:  begin w.jt = 3'd6; w.tgt = 10'd20; end
            20: begin w.jt = 3'd1; w.tgt = 10'd23; w.c = 1'b1; end
            23: begin w.jt = 3'd2; w.tgt = 10'd40; w.z = 1'b0; end
            24: begin w.jt = 3'd6; w.tgt = 10'd30; w.len_n = 1'b0; end
            30: begin w.jt = 3'd3; w.tgt = 10'd33; w.n = 1'b0; end
            33: begin w.jt = 3'd4; w.tgt = 10'd35; w.n = 1'b1; end
            35: begin w.jt = 3'd7; end
            25: begin w.jt = 3'd2; w.tgt = 10'd27; w.z = 1'b1; end
            27: begin w.jt = 3'd1; w.tgt = 10'd50; w.c = 1'b0; end
            28: begin w.jt = 3'd3; w.tgt = 10'd50; w.n = 1'b1; end
            29: begin w.jt = 3'd4; w.tgt = 10'd50; w.n = 1'b0; w.jt = 3'd4; end
            30+0: ;
            default: ;
         endcase
         if (a == 29) begin w.jt = 3'd4; w.n = 1'b0; w.tgt = 10'd50; end
         if (a == 31) begin w.jt = 3'd7; end
         if (a == 1)  begin w.jt = 3'd5; w.tgt = 10'd5; end
         if (a == 5)  begin w.len_n = 1'b0; w.rd = 1'b1; end
         if (a == 6)  begin w.csel = 1'b1; w.cval = 1'b1; w.len_n = 1'b0; end
      end else begin
         if (a == 0) begin w.jt = 3'd5; w.tgt = 10'd40; end
         else if (a >= 40 && a <= 72 && (a % 2) == 0) begin
            w.jt  = 3'd6;
            w.tgt = (a == 72) ? 10'd100 : 10'(a + 2);
         end else if (a >= 43 && a <= 73 && (a % 2) == 1) begin
            w.jt = 3'd7;
            if (a == 43) begin
               w.csel = 1'b1; w.cval = 1'b1; w.len_n = 1'b0; w.rd = 1'b1;
            end
         end else if (a == 100) w.jt = 3'd7;
      end
      return w;
   endfunction

   assign cur = fetch(prog_sel, int'(upc));

   mseq_core uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .ui_jtype      (cur.jt),
      .ui_target     (cur.tgt),
      .ui_time       (cur.tm),
      .ui_cin_sel    (cur.csel),
      .ui_cin_val    (cur.cval),
      .ui_latch_en_n (cur.len_n),
      .ui_mem_read   (cur.rd),
      .alu_c         (cur.c),
      .alu_z         (cur.z),
      .alu_n         (cur.n),
      .alu_y         (cur.y),
      .mem_rdata     (cur.rdata),
      .upc           (upc),
      .retire        (retire),
      .busy          (busy),
      .done          (done),
      .cycle_total   (cycle_total),
      .addr_latch    (addr_latch)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   item_t expq[$];
   int    model_latch = 0;
   int    exp_total;
   int    exp_final;
   int    done_seen;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] jt);
      case (jt)
         3'd0, 3'd5: return "R4";
         3'd6, 3'd7: return "R6";
         default:    return "R5";
      endcase
   endfunction

   // Driver: reference walk of the program, pushing expected retirements.
   task automatic predict(input int p);
      int stk [16];
      int sp = 0;
      int pc = 0;
      word_t w;
      item_t it;
      bit fin = 0;
      int dw;
      bit tk;
      for (int i = 0; i < 16; i++) stk[i] = 0;
      exp_total = 0;
      for (int step = 0; step < 2000 && !fin; step++) begin
         w  = fetch(p, pc);
         dw = (w.tm == 2'd3) ? 2 : 3 + int'(w.tm);
         exp_total += dw;
         if (!w.len_n) model_latch = w.rd ? int'(w.rdata) : int'(w.y);
         it.addr = pc; it.dwell = dw; it.latch = model_latch; it.tag = tag_of(w.jt);
         expq.push_back(it);
         fin = w.csel && w.cval;
         tk = 0;
         case (w.jt)
            3'd1: tk = w.c;
            3'd2: tk = w.z;
            3'd3: tk = !w.n;
            3'd4: tk = w.n;
            3'd5: tk = 1;
            default: tk = 0;
         endcase
         if (w.jt == 3'd6) begin
            stk[sp] = (pc + 1) % 1024; sp = (sp + 1) % 16; pc = int'(w.tgt);
         end else if (w.jt == 3'd7) begin
            sp = (sp + 15) % 16; pc = stk[sp];
         end else if (tk) pc = int'(w.tgt);
         else pc = (pc + 1) % 1024;
      end
      exp_final = pc;
   endtask

   // Monitor: compares each retirement against the queue head.
   int    in_word = 0;
   bit    latch_pend = 0;
   int    latch_exp;
   always @(negedge clk) begin
      item_t it;
      if (rst_n) begin
         if (done) begin
            done_seen++;
            check("R10 busy low with done", int'(busy), 0);
         end
         if (latch_pend) begin
            check("R9 address latch", int'(addr_latch), latch_exp);
            latch_pend = 0;
         end
         if (busy && retire) begin
            if (expq.size() == 0) begin
               check("R3 unexpected retirement", int'(upc), -1);
            end else begin
               it = expq.pop_front();
               check({it.tag, " retire address"}, int'(upc), it.addr);
               check("R8 dwell clocks", in_word + 1, it.dwell);
               latch_exp  = it.latch;
               latch_pend = 1;
            end
            in_word = 0;
         end else if (busy) in_word++;
         else in_word = 0;
      end
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_prog(input int p, input bit poke, input string wrap_req);
      int wd = 0;
      prog_sel = p;
      done_seen = 0;
      predict(p);
      pulse_start();
      check("R2 busy after start", int'(busy), 1);
      if (poke) begin
         repeat (7) @(negedge clk);
         pulse_start();   // R3: ignored while busy
      end
      while (!done && wd < 5000) begin @(negedge clk); wd++; end
      if (wd >= 5000) check("watchdog", 0, 1);
      check("R11 cycle total", int'(cycle_total), exp_total);
      check({wrap_req, " final address"}, int'(upc), exp_final);
      @(negedge clk);
      check("R10 busy low after run", int'(busy), 0);
      check("R10 done pulse count", done_seen, 1);
      check("R3 trace fully consumed", expq.size(), 0);
      expq.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      check("R1 retire", int'(retire), 0);
      check("R1 upc", int'(upc), 0);
      check("R1 cycle_total", int'(cycle_total), 0);
      check("R1 addr_latch", int'(addr_latch), 0);
      rst_n = 1'b1;
      run_prog(1, 1'b1, "R10");
      run_prog(2, 1'b0, "R7");
      run_prog(1, 1'b0, "R10");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule